// File: doc/BRIEF.md
# Descriptor-Chained Audio Playback DMA

This block is a bus-master engine that plays audio out of memory. Software places a table of 8-byte descriptors in memory, writes the address of the first one into the table pointer, and raises the enable input. The engine fetches a descriptor, streams the buffer that it names as 32-bit stereo sample words (16-bit left, 16-bit right) toward a link formatter, and then moves to the next descriptor. Each descriptor carries two flags. The end-of-page flag asks for an interrupt when its buffer has been drained. The jump flag turns the entry into a link to another place in the table, which is how a table forms a ring.

Memory is reached through a request/response port with at most one read in flight. A request is held on `mem_req_valid`/`mem_req_addr` until `mem_req_ready`. The response comes back as a single-cycle `mem_rsp_valid` pulse, and the engine always accepts it. The sample port is valid/ready. Once `smp_valid` is high, `smp_data` stays stable until `smp_ready` takes it. The only exceptions are pause and disable, which withdraw `smp_valid` while keeping the word. The consumer may hold `smp_ready` low for any time. Pause freezes the engine where it stands, and disable abandons the current position.

Top module: `adma_engine`

## Requirements
- R1: When running and idle, the engine reads descriptor word 0 (buffer byte address) at the table pointer and word 1 at pointer+4. When word 1 arrives, the pointer advances by 8. This does not happen for jump entries.
- R2: A data descriptor's buffer is delivered in ascending address order as one sample per 32-bit word. The word count is word 1 bits [15:2], and a count field of zero means 16384 words.
- R3: If word 1 bit 30 (end-of-page) is set, `stat_eop` and `irq` rise in the cycle after the buffer's last sample is accepted. The engine carries on with the next descriptor without waiting.
- R4: If word 1 bit 29 (jump) is set, no data is read and the table pointer is loaded with word 0. No interrupt results, even when bit 30 is also set.
- R5: While `pause` is high, `smp_valid` and `mem_req_valid` are low and the position is kept. After `pause` falls, the first sample offered is the one that was pending.
- R6: Lowering `enable` drops `smp_valid` and `mem_req_valid` at once and discards the buffer position. A read still outstanding is absorbed and ignored. On re-enable, the next fetch is at the current table pointer, which is the entry after the interrupted one.
- R7: A one-cycle `stat_rd` pulse clears `stat_eop` and `stat_err`, and `irq` is low in the following cycle. If an end-of-page event lands in the same cycle, `stat_eop` is set again.
- R8: An end-of-page event while `stat_eop` is still set raises `stat_err`. While `stat_err` is set, no further descriptor fetch or sample is started.
- R9: `smp_data` is held stable while `smp_valid` waits for `smp_ready`, unless it is withdrawn by pause or disable. No new memory request is raised while a read is outstanding.
- R10: After reset the table pointer is 0, both flags and `irq` are low, and no request or sample is offered.
- R11: A `tbl_wr` pulse loads `tbl_wdata` into the table pointer. The new value is visible on `tbl_ptr` the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr | input | 1 | Load table pointer |
| tbl_wdata | input | 32 | New table pointer value |
| tbl_ptr | output | 32 | Current table pointer |
| enable | input | 1 | Run the engine; low abandons the position |
| pause | input | 1 | Freeze in place |
| stat_rd | input | 1 | Status read pulse; clears the flags |
| stat_eop | output | 1 | End-of-page flag |
| stat_err | output | 1 | Missed-interrupt flag |
| irq | output | 1 | Interrupt, high while any flag is set |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read byte address, word aligned |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Read data |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | 32 | Sample, left in [31:16], right in [15:0] |

## Verification
The bench builds the engine with its default widths: a 32-bit address and sample word and a 16-bit count field with flags at bits 30 and 29. With these defaults, the largest buffer (a zero count, 16384 words) can be played in full and counted sample by sample. A small ring of two data entries and one jump entry exercises looping, missed interrupts and the error stall within a few hundred cycles. Random memory latency and ready gaps push the engine through every wait state. Pause and disable are applied while a sample is on offer, so the exact-resume and discard rules are observed at the ports.

// File: rtl/adma_pkg.sv
package adma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D0_REQ,
    ST_D0_RSP,
    ST_D1_REQ,
    ST_D1_RSP,
    ST_DAT_REQ,
    ST_DAT_RSP,
    ST_SEND
  } adma_state_e;

endpackage

// File: rtl/adma_buf_walk.sv
// Address and remaining-word counter for the buffer being played.
module adma_buf_walk #(
  parameter int AW         = 32,
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             step,
  output logic [AW-1:0]    buf_addr,
  output logic             last
);
  localparam int SH = $clog2(WORD_BYTES);
  localparam int WW = CNT_W - SH;
  localparam int RW = WW + 1;
  localparam logic [RW-1:0] FULL = RW'(1) << WW;

  logic [RW-1:0] rem_q;
  logic [WW-1:0] words;

  assign words = load_cnt[CNT_W-1:SH];
  assign last  = (rem_q == RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr <= '0;
      rem_q    <= '0;
    end else if (load) begin
      buf_addr <= load_addr;
      rem_q    <= (words == '0) ? FULL : {1'b0, words};
    end else if (step) begin
      buf_addr <= buf_addr + AW'(WORD_BYTES);
      rem_q    <= rem_q - RW'(1);
    end
  end
endmodule

// File: rtl/adma_irq_flags.sv
// End-of-page and missed-interrupt flags with clear-on-read.
module adma_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic eop_evt,
  input  logic rd,
  output logic eop_q,
  output logic err_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_q <= 1'b0;
      err_q <= 1'b0;
    end else if (rd) begin
      eop_q <= eop_evt;
      err_q <= 1'b0;
    end else begin
      eop_q <= eop_q | eop_evt;
      err_q <= err_q | (eop_evt & eop_q);
    end
  end

  assign irq = eop_q | err_q;
endmodule

// File: rtl/adma_engine.sv
module adma_engine #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  parameter int EOP_BIT = 30,
  parameter int JMP_BIT = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_wr,
  input  logic [AW-1:0] tbl_wdata,
  output logic [AW-1:0] tbl_ptr,
  input  logic          enable,
  input  logic          pause,
  input  logic          stat_rd,
  output logic          stat_eop,
  output logic          stat_err,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data
);
  import adma_pkg::*;

  localparam int WORD_BYTES = DW / 8;
  localparam int DESC_BYTES = 2 * WORD_BYTES;

  adma_state_e   st_q, st_d;
  logic [AW-1:0] ptr_q, w0_q, buf_addr;
  logic [DW-1:0] smp_q;
  logic          pend_q, eop_flag_q;
  logic          run, req_phase, req_fire, rsp_take, smp_fire;
  logic          buf_last, buf_load, eop_evt, d1_jump;

  assign run       = enable & ~pause;
  assign req_phase = (st_q == ST_D0_REQ) || (st_q == ST_D1_REQ) || (st_q == ST_DAT_REQ);
  assign mem_req_valid = run & req_phase;
  assign req_fire  = mem_req_valid & mem_req_ready;
  assign rsp_take  = mem_rsp_valid & pend_q;
  assign smp_valid = run & (st_q == ST_SEND);
  assign smp_data  = smp_q;
  assign smp_fire  = smp_valid & smp_ready;
  assign d1_jump   = mem_rsp_data[JMP_BIT];
  assign buf_load  = (st_q == ST_D1_RSP) & rsp_take & ~d1_jump;
  assign eop_evt   = smp_fire & buf_last & eop_flag_q;
  assign tbl_ptr   = ptr_q;

  always_comb begin
    case (st_q)
      ST_D0_REQ: mem_req_addr = ptr_q;
      ST_D1_REQ: mem_req_addr = ptr_q + AW'(WORD_BYTES);
      default:   mem_req_addr = buf_addr;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (run && !stat_err && !pend_q) st_d = ST_D0_REQ;
      ST_D0_REQ:  if (req_fire) st_d = ST_D0_RSP;
      ST_D0_RSP:  if (rsp_take) st_d = ST_D1_REQ;
      ST_D1_REQ:  if (req_fire) st_d = ST_D1_RSP;
      ST_D1_RSP:  if (rsp_take) st_d = d1_jump ? ST_IDLE : ST_DAT_REQ;
      ST_DAT_REQ: if (req_fire) st_d = ST_DAT_RSP;
      ST_DAT_RSP: if (rsp_take) st_d = ST_SEND;
      ST_SEND:    if (smp_fire) st_d = buf_last ? ST_IDLE : ST_DAT_REQ;
      default:    st_d = ST_IDLE;
    endcase
    if (!enable) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      w0_q       <= '0;
      smp_q      <= '0;
      pend_q     <= 1'b0;
      eop_flag_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (tbl_wr)
        ptr_q <= tbl_wdata;
      else if (st_q == ST_D1_RSP && rsp_take && enable)
        ptr_q <= d1_jump ? w0_q : ptr_q + AW'(DESC_BYTES);
      if (st_q == ST_D0_RSP && rsp_take) w0_q <= mem_rsp_data[AW-1:0];
      if (buf_load) eop_flag_q <= mem_rsp_data[EOP_BIT];
      if (st_q == ST_DAT_RSP && rsp_take) smp_q <= mem_rsp_data;
      if (req_fire)           pend_q <= 1'b1;
      else if (mem_rsp_valid) pend_q <= 1'b0;
    end
  end

  adma_buf_walk #(
    .AW(AW), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (buf_load),
    .load_addr (w0_q),
    .load_cnt  (mem_rsp_data[CNT_W-1:0]),
    .step      (smp_fire),
    .buf_addr  (buf_addr),
    .last      (buf_last)
  );

  adma_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .eop_evt (eop_evt),
    .rd      (stat_rd),
    .eop_q   (stat_eop),
    .err_q   (stat_err),
    .irq     (irq)
  );
endmodule

// File: rtl/adma_engine_chk.sv
module adma_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          pause,
  input logic          stat_rd,
  input logic          stat_eop,
  input logic          stat_err,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_rsp_valid,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [DW-1:0] smp_data
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) out_q <= 1'b1;
    else if (mem_rsp_valid) out_q <= 1'b0;
  end

  assert_sample_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (!enable || pause || (smp_valid && $stable(smp_data))));

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !out_q);

  assert_pause_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> (!smp_valid && !mem_req_valid));

  assert_disable_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!smp_valid && !mem_req_valid));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !stat_err);

  assert_eop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_eop) |-> $past(smp_valid && smp_ready));

  assert_err_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err) |-> $past(stat_eop));

  assert_err_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err |-> (!mem_req_valid && !smp_valid));
endmodule

bind adma_engine adma_engine_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .pause         (pause),
  .stat_rd       (stat_rd),
  .stat_eop      (stat_eop),
  .stat_err      (stat_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_rsp_valid (mem_rsp_valid),
  .smp_valid     (smp_valid),
  .smp_ready     (smp_ready),
  .smp_data      (smp_data)
);

// File: tb/test_adma_engine.sv
`timescale 1ns/1ps
module test_adma_engine;
  logic        clk = 1'b0;
  logic        rst_n, tbl_wr, enable, pause, stat_rd;
  logic [31:0] tbl_wdata, tbl_ptr, mem_req_addr, mem_rsp_data, smp_data;
  logic        stat_eop, stat_err, irq, mem_req_valid, mem_req_ready;
  logic        mem_rsp_valid, smp_valid, smp_ready;

  always #2 clk = ~clk;

  adma_engine i_adma_engine (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata), .tbl_ptr(tbl_ptr),
    .enable(enable), .pause(pause), .stat_rd(stat_rd), .stat_eop(stat_eop),
    .stat_err(stat_err), .irq(irq), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, hs_cnt = 0, lat = 0;
  logic [31:0] dmem [logic [31:0]];
  logic [31:0] exp_q[$];
  bit          exp_last_eop[$];
  logic [31:0] g_base[2];
  int          g_words[2];
  bit          g_eop[2];
  int          g_n = 0, g_idx = 0;
  bit          m_eop = 0, m_err = 0, outst = 0, fast = 0, auto_ack = 0, man_rd = 0, irq_seen = 0;
  logic [31:0] rsp_addr = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] dval(logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + a[15:0]};
  endfunction

  function automatic logic [31:0] mem_read(logic [31:0] a);
    if (dmem.exists(a)) return dmem[a];
    return dval(a);
  endfunction

  function automatic void refill();
    while (exp_q.size() < 8 && g_n > 0) begin
      for (int i = 0; i < g_words[g_idx]; i++) begin
        exp_q.push_back(dval(g_base[g_idx] + 32'(4 * i)));
        exp_last_eop.push_back(g_eop[g_idx] && (i == g_words[g_idx] - 1));
      end
      g_idx = (g_idx + 1) % g_n;
    end
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  // Drivers at the falling edge, reference model sampled 1 ns later.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    smp_ready     = fast ? 1'b1 : (lfsr[0] | lfsr[3]);
    mem_req_ready = fast ? 1'b1 : (lfsr[1] | lfsr[5]);
    stat_rd       = auto_ack ? irq_seen : man_rd;
    if (outst && lat == 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_read(rsp_addr);
    end else begin
      mem_rsp_valid = 1'b0;
      if (outst && lat > 0) lat--;
    end
    #1;
    if (rst_n) begin
      bit evt;
      evt = 0;
      chk(stat_eop == m_eop, "R3", "eop flag", 32'(stat_eop), 32'(m_eop));
      chk(stat_err == m_err, "R8", "err flag", 32'(stat_err), 32'(m_err));
      chk(irq == (m_eop | m_err), "R7", "irq", 32'(irq), 32'(m_eop | m_err));
      if (smp_valid && smp_ready) begin
        hs_cnt++;
        if (exp_q.size() == 0) chk(0, "R2", "unexpected sample", smp_data, 32'h0);
        else begin
          chk(smp_data == exp_q[0], "R2", "sample data", smp_data, exp_q[0]);
          evt = exp_last_eop[0];
          void'(exp_q.pop_front());
          void'(exp_last_eop.pop_front());
          refill();
        end
      end
      if (mem_rsp_valid) outst = 0;
      if (mem_req_valid) begin
        if (outst) chk(0, "R9", "request while read outstanding", mem_req_addr, rsp_addr);
        if (mem_req_ready) begin
          outst    = 1;
          rsp_addr = mem_req_addr;
          lat      = fast ? 0 : int'(lfsr[2:1]) % 3;
        end
      end
      if (stat_rd) begin
        m_eop = evt;
        m_err = 0;
      end else begin
        m_err = m_err | (evt & m_eop);
        m_eop = m_eop | evt;
      end
      irq_seen = irq;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hs0;
    rst_n = 0; tbl_wr = 0; tbl_wdata = '0; enable = 0; pause = 0;
    mem_rsp_valid = 0; mem_rsp_data = '0; smp_ready = 0; mem_req_ready = 0; stat_rd = 0;
    dmem[32'h100] = 32'h0000_1000; dmem[32'h104] = 32'h4000_000C;
    dmem[32'h108] = 32'h0000_2000; dmem[32'h10C] = 32'h0000_0008;
    dmem[32'h110] = 32'h0000_0100; dmem[32'h114] = 32'h6000_0000;
    dmem[32'h200] = 32'h0001_0000; dmem[32'h204] = 32'h4000_0000;
    dmem[32'h208] = 32'h0000_0200; dmem[32'h20C] = 32'h2000_0000;
    repeat (4) step();
    rst_n = 1;
    step();
    // R10: reset state
    chk(tbl_ptr == 0, "R10", "table pointer", tbl_ptr, 32'h0);
    chk(!irq && !stat_eop && !stat_err, "R10", "flags", {stat_eop, stat_err, irq}, 32'h0);
    chk(!smp_valid && !mem_req_valid, "R10", "valids", {smp_valid, mem_req_valid}, 32'h0);
    // R11: pointer load
    tbl_wr = 1; tbl_wdata = 32'h100;
    step();
    tbl_wr = 0;
    chk(tbl_ptr == 32'h100, "R11", "pointer after write", tbl_ptr, 32'h100);

    g_base[0] = 32'h1000; g_words[0] = 3; g_eop[0] = 1;
    g_base[1] = 32'h2000; g_words[1] = 2; g_eop[1] = 0;
    g_n = 2; g_idx = 0;
    refill();
    auto_ack = 1;
    enable = 1;
    while (!mem_req_valid) step();
    chk(mem_req_addr == 32'h100, "R1", "first fetch address", mem_req_addr, 32'h100);
    while (tbl_ptr != 32'h108) step();
    chk(!smp_valid, "R1", "pointer advances before data", 32'(smp_valid), 32'h0);
    // R3 and R4: three laps of the ring, each raising exactly one interrupt
    for (int k = 0; k < 3; k++) begin
      while (!irq) step();
      while (irq) step();
    end
    // R8: leave the flag unread until a second event is missed
    auto_ack = 0;
    while (!stat_err) step();
    chk(stat_eop, "R8", "eop still set with err", 32'(stat_eop), 32'h1);
    for (int k = 0; k < 20; k++) begin
      step();
      chk(!smp_valid && !mem_req_valid, "R8", "stalled on err", {smp_valid, mem_req_valid}, 32'h0);
    end
    man_rd = 1;
    step();
    man_rd = 0;
    step(); step();
    chk(!stat_err && !stat_eop, "R7", "flags after read", {stat_eop, stat_err}, 32'h0);
    auto_ack = 1;
    // R5: pause while a sample is on offer
    while (!smp_valid) step();
    pause = 1;
    step();
    for (int k = 0; k < 10; k++) begin
      chk(!smp_valid && !mem_req_valid, "R5", "quiet in pause", {smp_valid, mem_req_valid}, 32'h0);
      step();
    end
    pause = 0;
    while (!smp_valid) step();
    chk(smp_data == exp_q[0], "R5", "resume sample", smp_data, exp_q[0]);
    // R6: disable in the middle of the first buffer
    while (!(smp_valid && exp_q.size() > 0 && exp_q[0] == dval(32'h1004))) step();
    enable = 0;
    step();
    chk(!smp_valid && !mem_req_valid, "R6", "quiet when disabled", {smp_valid, mem_req_valid}, 32'h0);
    repeat (8) step();
    chk(tbl_ptr == 32'h108, "R6", "pointer after disable", tbl_ptr, 32'h108);
    exp_q.delete(); exp_last_eop.delete();
    g_idx = 1;
    refill();
    enable = 1;
    while (!mem_req_valid) step();
    chk(mem_req_addr == 32'h108, "R6", "refetch address", mem_req_addr, 32'h108);
    hs0 = hs_cnt;
    while (hs_cnt < hs0 + 7) step();
    // R2: zero count plays 16384 words
    enable = 0;
    repeat (8) step();
    tbl_wr = 1; tbl_wdata = 32'h200;
    step();
    tbl_wr = 0;
    fast = 1;
    exp_q.delete(); exp_last_eop.delete();
    g_base[0] = 32'h10000; g_words[0] = 16384; g_eop[0] = 1;
    g_n = 1; g_idx = 0;
    refill();
    hs0 = hs_cnt;
    enable = 1;
    while (!irq) step();
    chk(hs_cnt - hs0 == 16384, "R2", "zero-count length", 32'(hs_cnt - hs0), 32'd16384);
    // R4: jump entry reloads the pointer from its address word
    hs0 = hs_cnt;
    while (hs_cnt == hs0) step();
    chk(tbl_ptr == 32'h208, "R4", "pointer after jump and refetch", tbl_ptr, 32'h208);
    enable = 0;
    repeat (4) step();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule